// File: doc/BRIEF.md
# ADC Window Threshold Watchdog

This block monitors converter results for two dedicated input channels, 6 and 7. Each channel has its own programmable window, made of an upper and a lower 8-bit limit. When a result strobe carries a sample from one of those two channels, the block compares the sample against that channel's limits. A sample outside the window sets a sticky flag for that channel and that limit, and it also sets a request flag. The interrupt line is the request flag gated by a mask input.

The window is asymmetric. A sample equal to the lower limit is inside the window, and a sample equal to the upper limit is outside it. Software cannot clear the flags directly. Pulsing the request-clear input clears the request flag, and in the same clock the hardware also drops all four flags.

The block also holds the converter power bit. After the power bit turns on, a bias settling counter runs for a parameterized number of clocks. Until that counter expires, conversion-start requests are blocked. The halt input forces the power bit off.

Top module: `adc_window_guard`

## Requirements
- R1: After reset the block is in this state:
  - all four flags and the request flag are 0;
  - the power bit is 0, and conv_ready_o, conv_start_o and irq_o are 0;
  - the upper limits read 0xFF and the lower limits read 0x00.
- R2: A valid result whose res_chan_i (3 bits) is neither 6 nor 7 changes no flag and does not set the request flag.
- R3: A valid result on channel 6 or 7 that is greater than or equal to that channel's upper limit sets the upper flag. That flag is compare-register bit 7 for channel 6 and bit 5 for channel 7. The flag is visible after the clock edge that samples the result.
- R4: A valid result on channel 6 or 7 that is strictly less than that channel's lower limit sets the lower flag. That flag is bit 6 for channel 6 and bit 4 for channel 7. If the limits are crossed (lower limit above upper limit), one result can set both flags.
- R5: A result equal to the lower limit, or equal to the upper limit minus one, leaves that channel's flags unchanged.
- R6: The register interface uses these addresses:

  | Address | Contents | Access |
  |---------|----------|--------|
  | 0x8 | channel 6 upper limit | read/write |
  | 0x9 | channel 6 lower limit | read/write |
  | 0xA | channel 7 upper limit | read/write |
  | 0xB | channel 7 lower limit | read/write |
  | 0x4 | compare flags in bits 7:4, bits 3:0 read 0 | read-only |
  | 0x1 | bit 0 request flag, bit 1 conv_ready | read-only |
  | 0x0 | bit 0 power bit | read/write |
  | any other address | reads 0 | — |

  Writes to 0x1, 0x4 and unused addresses have no effect. A write is visible after its clock edge. A result sampled on the same edge as a limit write is compared with the old limit.
- R7: Each out-of-range result sets the request flag on the same clock edge as its flag. Flags stay set through later violations and later in-range results.
- R8: A req_clr_i pulse clears the request flag and all four flags on that edge. If a violation is sampled on the same edge, the request flag remains set and only the new flags are set.
- R9: irq_o equals the request flag AND irq_mask_i. The mask does not affect the flags or the request flag.
- R10: The counter starts on the edge that sets the power bit. conv_ready_o rises SETTLE_CYCLES edges after that edge. conv_start_o equals start_i AND conv_ready_o, so a start request made before the counter expires is ignored. Writing 0 to the power bit drops ready at once.
- R11: halt_i forces the power bit to 0 on that edge, and conv_ready_o drops with it. halt_i wins over a simultaneous write of 1 to the power bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register address for reads and writes |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Combinational read data for reg_addr_i |
| res_valid_i | input | 1 | Conversion result strobe |
| res_chan_i | input | 3 | Channel that produced the result |
| res_data_i | input | 8 | Conversion result |
| irq_mask_i | input | 1 | Interrupt enable |
| req_clr_i | input | 1 | Request-flag clear pulse |
| halt_i | input | 1 | Halt indication, forces power off |
| start_i | input | 1 | Conversion start request |
| conv_ready_o | output | 1 | Power on and bias settled |
| conv_start_o | output | 1 | Start request passed to the converter |
| irq_o | output | 1 | Masked watchdog interrupt request |

## Verification
Flags, the request flag and limit writes take effect one edge after they are sampled, and they are read back combinationally in the following cycle. irq_o and conv_start_o follow their inputs within the same cycle. conv_ready_o rises exactly SETTLE_CYCLES edges after the power-on write. The bench keeps a behavioural model that it updates on each rising edge from the inputs it drove. It compares every output and the currently addressed register shortly after each falling edge. This way every result is checked in the first cycle in which it is due, and again in every later cycle.

// File: rtl/awg_pkg.sv
package awg_pkg;

   // Number of guarded channels and the flags they produce (upper + lower each)
   localparam int unsigned NUM_WIN  = 2;
   localparam int unsigned NUM_FLAG = 2 * NUM_WIN;
   localparam int unsigned NUM_THR  = 2 * NUM_WIN;

   typedef struct packed {
      logic up;
      logic lo;
   } win_hit_t;

endpackage

// File: rtl/awg_cmp.sv
module awg_cmp
   import awg_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              hit_i,
   input  logic [DATA_W-1:0] res_i,
   input  logic [DATA_W-1:0] up_i,
   input  logic [DATA_W-1:0] lo_i,
   output win_hit_t          viol_o
);

   // Asymmetric window: equal to upper is out, equal to lower is in
   always_comb begin
      viol_o.up = hit_i && (res_i >= up_i);
      viol_o.lo = hit_i && (res_i <  lo_i);
   end

endmodule

// File: rtl/awg_regs.sv
module awg_regs #(
   parameter int DATA_W    = 8,
   parameter int ADDR_W    = 4,
   parameter int NUM_THR   = 4,
   parameter int THR_BASE  = 8,
   parameter int CTRL_ADDR = 0
) (
   input  logic                           clk_i,
   input  logic                           rst_ni,
   input  logic                           wr_i,
   input  logic [ADDR_W-1:0]              addr_i,
   input  logic [DATA_W-1:0]              wdata_i,
   input  logic                           halt_i,
   output logic [NUM_THR-1:0][DATA_W-1:0] thr_o,
   output logic                           pwr_o
);

   generate
      if (THR_BASE + NUM_THR > (1 << ADDR_W)) begin : g_bad_map
         $error("awg_regs: threshold block does not fit the address space");
      end
   endgenerate

   // Limit registers: even index is an upper limit, odd index a lower limit
   generate
      for (genvar j = 0; j < NUM_THR; j++) begin : g_thr
         localparam logic [DATA_W-1:0] RST_VAL = (j % 2 == 0) ? {DATA_W{1'b1}} : {DATA_W{1'b0}};
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)
               thr_o[j] <= RST_VAL;
            else if (wr_i && addr_i == ADDR_W'(THR_BASE + j))
               thr_o[j] <= wdata_i;
         end
      end
   endgenerate

   // Power bit, halt has priority over software
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
         pwr_o <= 1'b0;
      else if (halt_i)
         pwr_o <= 1'b0;
      else if (wr_i && addr_i == ADDR_W'(CTRL_ADDR))
         pwr_o <= wdata_i[0];
   end

   p_halt_off_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      halt_i |=> !pwr_o);

   p_pwr_write_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_i && !halt_i && addr_i == ADDR_W'(CTRL_ADDR)) |=> (pwr_o == $past(wdata_i[0])));

endmodule

// File: rtl/awg_settle.sv
module awg_settle #(
   parameter int CYCLES = 16
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic pwr_i,
   output logic ready_o
);

   localparam int CNT_W = $clog2(CYCLES + 1);
   localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(CYCLES);

   generate
      if (CYCLES < 2) begin : g_bad_cycles
         $error("awg_settle: CYCLES must be at least 2");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;

   // Counts from the power-on edge and saturates; reloaded while power is off
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
         cnt_q <= '0;
      else if (!pwr_i)
         cnt_q <= '0;
      else if (cnt_q != CNT_MAX)
         cnt_q <= cnt_q + 1'b1;
   end

   assign ready_o = pwr_i && (cnt_q == CNT_MAX);

   p_no_early_ready_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(pwr_i) |-> !ready_o);

   p_ready_stays_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ready_o && pwr_i) |=> (ready_o || !pwr_i));

endmodule

// File: rtl/adc_window_guard.sv
module adc_window_guard
   import awg_pkg::*;
#(
   parameter int DATA_W        = 8,
   parameter int ADDR_W        = 4,
   parameter int CHAN_W        = 3,
   parameter int FIRST_CH      = 6,
   parameter int SETTLE_CYCLES = 16,
   parameter int REG_CTRL      = 0,
   parameter int REG_STAT      = 1,
   parameter int REG_CMP       = 4,
   parameter int REG_THR       = 8
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              reg_wr_i,
   input  logic [ADDR_W-1:0] reg_addr_i,
   input  logic [DATA_W-1:0] reg_wdata_i,
   output logic [DATA_W-1:0] reg_rdata_o,
   input  logic              res_valid_i,
   input  logic [CHAN_W-1:0] res_chan_i,
   input  logic [DATA_W-1:0] res_data_i,
   input  logic              irq_mask_i,
   input  logic              req_clr_i,
   input  logic              halt_i,
   input  logic              start_i,
   output logic              conv_ready_o,
   output logic              conv_start_o,
   output logic              irq_o
);

   generate
      if (DATA_W < NUM_FLAG) begin : g_bad_width
         $error("adc_window_guard: DATA_W too small for the flag field");
      end
      if (FIRST_CH + NUM_WIN > (1 << CHAN_W)) begin : g_bad_chan
         $error("adc_window_guard: guarded channels exceed channel index range");
      end
   endgenerate

   logic [NUM_THR-1:0][DATA_W-1:0] thr_w;
   logic                           pwr_w;
   logic [NUM_FLAG-1:0]            vio_w;
   logic [NUM_FLAG-1:0]            flags_q;
   logic                           req_q;
   logic                           any_vio;

   awg_regs #(
      .DATA_W   (DATA_W),
      .ADDR_W   (ADDR_W),
      .NUM_THR  (NUM_THR),
      .THR_BASE (REG_THR),
      .CTRL_ADDR(REG_CTRL)
   ) u_regs (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .wr_i   (reg_wr_i),
      .addr_i (reg_addr_i),
      .wdata_i(reg_wdata_i),
      .halt_i (halt_i),
      .thr_o  (thr_w),
      .pwr_o  (pwr_w)
   );

   awg_settle #(
      .CYCLES(SETTLE_CYCLES)
   ) u_settle (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .pwr_i  (pwr_w),
      .ready_o(conv_ready_o)
   );

   // One comparator per guarded channel; channel k flags sit at the top bits
   generate
      for (genvar k = 0; k < NUM_WIN; k++) begin : g_win
         win_hit_t viol;
         logic     hit;
         assign hit = res_valid_i && (res_chan_i == CHAN_W'(FIRST_CH + k));
         awg_cmp #(
            .DATA_W(DATA_W)
         ) u_cmp (
            .hit_i (hit),
            .res_i (res_data_i),
            .up_i  (thr_w[2*k]),
            .lo_i  (thr_w[2*k+1]),
            .viol_o(viol)
         );
         assign vio_w[NUM_FLAG-1-2*k] = viol.up;
         assign vio_w[NUM_FLAG-2-2*k] = viol.lo;
      end
   endgenerate

   assign any_vio = |vio_w;

   // Sticky flags; a request clear also wipes them, new hits on that edge survive
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         flags_q <= '0;
         req_q   <= 1'b0;
      end else if (req_clr_i) begin
         flags_q <= vio_w;
         req_q   <= any_vio;
      end else begin
         flags_q <= flags_q | vio_w;
         req_q   <= req_q | any_vio;
      end
   end

   assign irq_o        = req_q & irq_mask_i;
   assign conv_start_o = start_i & conv_ready_o;

   always_comb begin
      reg_rdata_o = '0;
      if (reg_addr_i == ADDR_W'(REG_CTRL))
         reg_rdata_o[0] = pwr_w;
      else if (reg_addr_i == ADDR_W'(REG_STAT))
         reg_rdata_o[1:0] = {conv_ready_o, req_q};
      else if (reg_addr_i == ADDR_W'(REG_CMP))
         reg_rdata_o = {flags_q, {(DATA_W-NUM_FLAG){1'b0}}};
      else
         for (int j = 0; j < NUM_THR; j++)
            if (reg_addr_i == ADDR_W'(REG_THR + j))
               reg_rdata_o = thr_w[j];
   end

   p_upper_hit_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (res_valid_i && res_chan_i == CHAN_W'(FIRST_CH) && res_data_i >= thr_w[0])
      |=> (flags_q[NUM_FLAG-1] && req_q));

   p_lower_hit_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (res_valid_i && res_chan_i == CHAN_W'(FIRST_CH) && res_data_i < thr_w[1])
      |=> (flags_q[NUM_FLAG-2] && req_q));

   p_other_chan_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (res_valid_i && !req_clr_i && (res_chan_i < CHAN_W'(FIRST_CH))) |=> $stable(flags_q));

   p_in_window_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (res_valid_i && !req_clr_i && res_chan_i == CHAN_W'(FIRST_CH)
       && res_data_i < thr_w[0] && res_data_i >= thr_w[1])
      |=> $stable(flags_q[NUM_FLAG-1 -: 2]));

   p_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !req_clr_i |=> ((flags_q & $past(flags_q)) == $past(flags_q)));

   p_flag_has_req_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flags_q != '0) |-> req_q);

   p_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_clr_i && !res_valid_i) |=> (flags_q == '0 && !req_q));

endmodule

// File: tb/sim_adc_window_guard.sv
module sim_adc_window_guard;

   localparam int CLK_PERIOD = 10;
   localparam int SETTLE     = 12;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_wr = 1'b0;
   logic [3:0] reg_addr = 4'h0;
   logic [7:0] reg_wdata = 8'h00;
   logic [7:0] reg_rdata;
   logic       res_valid = 1'b0;
   logic [2:0] res_chan = 3'd0;
   logic [7:0] res_data = 8'h00;
   logic       irq_mask = 1'b0;
   logic       req_clr = 1'b0;
   logic       halt = 1'b0;
   logic       start = 1'b0;
   logic       conv_ready, conv_start, irq;

   always #(CLK_PERIOD/2) clk = ~clk;

   adc_window_guard #(.SETTLE_CYCLES(SETTLE)) u0 (
      .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(reg_wr), .reg_addr_i(reg_addr),
      .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .res_valid_i(res_valid),
      .res_chan_i(res_chan), .res_data_i(res_data), .irq_mask_i(irq_mask),
      .req_clr_i(req_clr), .halt_i(halt), .start_i(start),
      .conv_ready_o(conv_ready), .conv_start_o(conv_start), .irq_o(irq)
   );

   // Behavioural reference state
   int    m_th[4];
   int    m_flags = 0;
   bit    m_req = 0;
   bit    m_pwr = 0;
   int    m_cnt = 0;
   int    checks = 0;
   int    fails = 0;
   int    rot = 0;
   bit    start_hold = 0;
   string phase = "R1";

   initial begin
      m_th[0] = 255; m_th[1] = 0; m_th[2] = 255; m_th[3] = 0;
   end

   always @(posedge clk) begin : model
      int vio;
      int k;
      vio = 0;
      if (!rst_n) begin
         m_th[0] = 255; m_th[1] = 0; m_th[2] = 255; m_th[3] = 0;
         m_flags = 0; m_req = 0; m_pwr = 0; m_cnt = 0;
      end else begin
         if (res_valid && (res_chan == 3'd6 || res_chan == 3'd7)) begin
            k = int'(res_chan) - 6;
            if (int'(res_data) >= m_th[2*k])  vio = vio | (8 >> (2*k));
            if (int'(res_data) <  m_th[2*k+1]) vio = vio | (4 >> (2*k));
         end
         if (req_clr) begin
            m_flags = vio;
            m_req   = (vio != 0);
         end else begin
            m_flags = m_flags | vio;
            if (vio != 0) m_req = 1;
         end
         if (!m_pwr) m_cnt = 0;
         else if (m_cnt < SETTLE) m_cnt++;
         if (reg_wr && reg_addr >= 4'h8 && reg_addr <= 4'hB)
            m_th[int'(reg_addr) - 8] = int'(reg_wdata);
         if (halt) m_pwr = 0;
         else if (reg_wr && reg_addr == 4'h0) m_pwr = reg_wdata[0];
      end
   end

   function automatic bit exp_ready();
      return m_pwr && (m_cnt == SETTLE);
   endfunction

   function automatic int exp_rdata(input logic [3:0] a);
      case (a)
         4'h0:                  return int'(m_pwr);
         4'h1:                  return (int'(exp_ready()) << 1) | int'(m_req);
         4'h4:                  return m_flags << 4;
         4'h8, 4'h9, 4'hA, 4'hB: return m_th[int'(a) - 8];
         default:               return 0;
      endcase
   endfunction

   task automatic chk(input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", phase, what, act, exp);
      end
   endtask

   // Compare every output shortly after each falling edge
   always @(negedge clk) begin
      if (rst_n) begin
         #2;
         chk("irq_o (R9)", int'(irq), int'(m_req && irq_mask));
         chk("conv_ready_o (R10)", int'(conv_ready), int'(exp_ready()));
         chk("conv_start_o (R10)", int'(conv_start), int'(start && exp_ready()));
         chk($sformatf("reg_rdata_o @%0h (R6)", reg_addr), int'(reg_rdata), exp_rdata(reg_addr));
      end
   end

   function automatic logic [3:0] rot_addr(input int r);
      case (r % 8)
         0: return 4'h4;
         1: return 4'h1;
         2: return 4'h0;
         3: return 4'h8;
         4: return 4'h9;
         5: return 4'hA;
         6: return 4'hB;
         default: return 4'h2;
      endcase
   endfunction

   task automatic defaults();
      reg_wr = 0; reg_wdata = 8'h00; res_valid = 0; res_chan = 3'd0; res_data = 8'h00;
      req_clr = 0; halt = 0; start = start_hold;
      reg_addr = rot_addr(rot); rot++;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); defaults();
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk); defaults();
      reg_wr = 1; reg_addr = a; reg_wdata = d;
   endtask

   task automatic res(input logic [2:0] ch, input logic [7:0] d, input bit clr);
      @(negedge clk); defaults();
      res_valid = 1; res_chan = ch; res_data = d; req_clr = clr;
   endtask

   task automatic clr();
      @(negedge clk); defaults(); req_clr = 1;
   endtask

   initial begin : watchdog
      #(CLK_PERIOD * 200000);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin : stim
      repeat (3) @(negedge clk);
      rst_n = 1;
      phase = "R1"; idle(10);

      phase = "R6";
      wr(4'h8, 8'hC0); wr(4'h9, 8'h40); wr(4'hA, 8'hA0); wr(4'hB, 8'h20);
      wr(4'h4, 8'hFF); wr(4'h1, 8'hFF); wr(4'h3, 8'h55); wr(4'hF, 8'h77);
      idle(9);

      phase = "R5";
      res(3'd6, 8'h40, 0); res(3'd6, 8'hBF, 0); res(3'd7, 8'h20, 0); res(3'd7, 8'h9F, 0);
      idle(8);

      phase = "R2";
      res(3'd0, 8'hFF, 0); res(3'd5, 8'h00, 0); res(3'd1, 8'hFF, 0); res(3'd2, 8'h00, 0);
      idle(8);

      phase = "R3";
      res(3'd6, 8'hC0, 0); idle(8);
      res(3'd7, 8'hFF, 0); idle(8);

      phase = "R7";
      res(3'd6, 8'hFF, 0); res(3'd6, 8'h80, 0); idle(8);

      phase = "R9";
      irq_mask = 1; idle(3); irq_mask = 0; idle(2);

      phase = "R8";
      clr(); idle(8);

      phase = "R4";
      irq_mask = 1;
      res(3'd6, 8'h3F, 0); idle(8);
      res(3'd7, 8'h1F, 1); idle(8);
      wr(4'h8, 8'h10); wr(4'h9, 8'h80);
      res(3'd6, 8'h10, 0); wr(4'h9, 8'h00);
      res(3'd6, 8'h50, 0); idle(8);
      clr(); idle(4);
      irq_mask = 0;

      phase = "R10";
      start_hold = 1; idle(4);
      wr(4'h0, 8'h01); idle(SETTLE + 6);
      wr(4'h0, 8'h00); idle(4);
      wr(4'h0, 8'h01); idle(SETTLE + 3);

      phase = "R11";
      @(negedge clk); defaults(); halt = 1; idle(4);
      @(negedge clk); defaults(); halt = 1; reg_wr = 1; reg_addr = 4'h0; reg_wdata = 8'h01;
      idle(4);
      start_hold = 0; idle(2);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule